// File: doc/BRIEF.md
# Serial Speech ROM Controller

This block is a serial-access data ROM of the kind that feeds a speech synthesizer. A host drives it over a 4-bit nibble bus and a 2-bit command field. Each command takes effect only when a one-cycle strobe is high. The host first loads a byte address a nibble at a time. It then issues read strobes. Each read strobe returns one bit or one nibble of the stored data, selected by a static mode input, and moves an internal bit pointer forward.

The first read after an address load is a dummy read. It commits the loaded address to the pointer and returns no new data. An indirect command reads a little-endian 16-bit word at the loaded address, keeps 14 bits of it as a byte address, and moves the pointer there with no dummy read needed. The ROM contents come from a fixed arithmetic function of the byte address, so the array synthesizes without a data file.

Top module: `serial_rom_ctrl`

## Requirements
- R1: Commands are decoded only on a clock edge where `strobe` is high. The encoding on `cmd` is 2'b01 read, 2'b10 load-address nibble, 2'b11 indirect, and 2'b00 no-op. Without a strobe, or with a no-op, neither `dataOut` nor the pointer changes.
- R2: Each load strobe writes `addrNib` into the next nibble of the address latch, starting at bits 3:0 and moving upward. After four nibbles, further load nibbles are ignored until the next commit or indirect command. Every load strobe marks a dummy read as pending.
- R3: A read strobe while a dummy read is pending copies the latched address into the pointer as byte address times 8. It clears the latch, the nibble counter and the pending mark, and leaves `dataOut` unchanged.
- R4: In nibble mode (`nibbleMode`=1), each read returns bits 7:4 of the current byte and then bits 3:0 of that byte, and advances the pointer by 4 bits. Consecutive reads therefore run across byte boundaries.
- R5: In bit mode (`nibbleMode`=0), each read returns the bit selected by pointer bits 2:0 on `dataOut[0]`, least significant bit first. `dataOut[3:1]` is zero, and the pointer advances by 1.
- R6: An indirect strobe forms a word from the byte at the latched address (low byte) and the byte at the next address (high byte). It keeps the low 14 bits of that word as the new byte address and clears the latch, the counter and the pending mark. The next read returns real data.
- R7: The asynchronous active-low reset sets `dataOut`, the pointer and the latch to zero and clears the pending mark. A read right after reset returns the high nibble of byte 0.
- R8: A committed address keeps only its low 14 bits. Latch bits above bit 13 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nibbleMode | input | 1 | Static mode: 1 returns nibbles, 0 returns single bits |
| strobe | input | 1 | One-cycle command qualifier (ROM clock) |
| cmd | input | 2 | Command: bit 0 read-type, bit 1 address-type |
| addrNib | input | 4 | Address nibble for load commands |
| dataOut | output | 4 | Registered read data |

## Verification
The assertions assume that `nibbleMode` stays fixed between resets and that `strobe` is a single-cycle pulse sampled on the rising edge. Under those conditions each strobed read moves the pointer by exactly 4 or 1 bits, and a pending dummy read never alters the output. The bench changes the mode only while reset is held. It raises `strobe` for exactly one cycle per command and drives all inputs on the falling edge, so each command meets the assumptions the properties rely on.

// File: rtl/srom_pkg.sv
package srom_pkg;

  localparam int POS_W = 3;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_READ = 2'b01,
    CMD_LOAD = 2'b10,
    CMD_IND  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic             loadNib;
    logic [POS_W-1:0] loadPos;
    logic             commit;
    logic             readOut;
    logic             indirect;
  } ctl_s;

  // fixed content: a mixing function of the byte address
  function automatic logic [7:0] romByte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd13;
    return t ^ {a[13:8], a[13:12]} ^ 8'hA5;
  endfunction

endpackage

// File: rtl/srom_ctrl.sv
module srom_ctrl
  import srom_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic [1:0] cmd,
  output ctl_s       ctl
);
  localparam int NIBS = (ADDR_W + 3) / 4;

  cmd_e             cmdE;
  logic             dummyPend;
  logic [POS_W-1:0] loadCnt;
  logic             isRead, isLoad, isInd;

  assign cmdE   = cmd_e'(cmd);
  assign isRead = strobe && (cmdE == CMD_READ);
  assign isLoad = strobe && (cmdE == CMD_LOAD);
  assign isInd  = strobe && (cmdE == CMD_IND);

  always_comb begin
    ctl          = '0;
    ctl.loadNib  = isLoad && (loadCnt < POS_W'(NIBS));
    ctl.loadPos  = loadCnt;
    ctl.commit   = isRead && dummyPend;
    ctl.readOut  = isRead && !dummyPend;
    ctl.indirect = isInd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dummyPend <= 1'b0;
      loadCnt   <= '0;
    end else if (ctl.commit || ctl.indirect) begin
      dummyPend <= 1'b0;
      loadCnt   <= '0;
    end else if (isLoad) begin
      dummyPend <= 1'b1;
      if (ctl.loadNib) loadCnt <= loadCnt + POS_W'(1);
    end
  end

  a_r2_load_pends: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> dummyPend);
  a_r6_ind_no_dummy: assert property (@(posedge clk) disable iff (!rstN)
    isInd |=> !dummyPend);
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> $stable(dummyPend) && $stable(loadCnt));
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt <= POS_W'(NIBS));

endmodule

// File: rtl/srom_datapath.sv
module srom_datapath
  import srom_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nibbleMode,
  input  logic [3:0] addrNib,
  input  ctl_s       ctl,
  output logic [3:0] dataOut
);
  localparam int NIBS    = (ADDR_W + 3) / 4;
  localparam int LATCH_W = NIBS * 4;
  localparam int PTR_W   = ADDR_W + 3;

  logic [LATCH_W-1:0] addrLatch;
  logic [PTR_W-1:0]   bitPtr;
  logic [ADDR_W-1:0]  latchAddr, curAddr;
  logic [7:0]         curByte, indLo, indHi;
  logic [15:0]        indWord;

  genvar g;
  generate
    for (g = 0; g < NIBS; g++) begin : gLatch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          addrLatch[g*4 +: 4] <= 4'h0;
        else if (ctl.commit || ctl.indirect)
          addrLatch[g*4 +: 4] <= 4'h0;
        else if (ctl.loadNib && ctl.loadPos == POS_W'(g))
          addrLatch[g*4 +: 4] <= addrNib;
      end
    end
  endgenerate

  assign latchAddr = addrLatch[ADDR_W-1:0];
  assign curAddr   = bitPtr[PTR_W-1:3];
  assign curByte   = romByte(16'(curAddr));
  assign indLo     = romByte(16'(latchAddr));
  assign indHi     = romByte(16'(latchAddr + ADDR_W'(1)));
  assign indWord   = {indHi, indLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPtr  <= '0;
      dataOut <= 4'h0;
    end else if (ctl.commit) begin
      bitPtr <= {latchAddr, 3'b000};
    end else if (ctl.indirect) begin
      bitPtr <= {indWord[ADDR_W-1:0], 3'b000};
    end else if (ctl.readOut) begin
      if (nibbleMode) begin
        dataOut <= bitPtr[2] ? curByte[3:0] : curByte[7:4];
        bitPtr  <= bitPtr + PTR_W'(4);
      end else begin
        dataOut <= {3'b000, curByte[bitPtr[2:0]]};
        bitPtr  <= bitPtr + PTR_W'(1);
      end
    end
  end

  a_r3_dummy_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> $stable(dataOut));
  a_r4_nibble_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readOut && nibbleMode |=> bitPtr == $past(bitPtr) + PTR_W'(4));
  a_r5_bit_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readOut && !nibbleMode |=> dataOut[3:1] == 3'b000);
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadNib, ctl.commit, ctl.readOut, ctl.indirect}));
  a_r1_no_action_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.commit || ctl.indirect || ctl.readOut) |=> $stable(bitPtr) && $stable(dataOut));

endmodule

// File: rtl/serial_rom_ctrl.sv
module serial_rom_ctrl
  import srom_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nibbleMode,
  input  logic       strobe,
  input  logic [1:0] cmd,
  input  logic [3:0] addrNib,
  output logic [3:0] dataOut
);
  ctl_s ctl;

  srom_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cmd    (cmd),
    .ctl    (ctl)
  );

  srom_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .nibbleMode (nibbleMode),
    .addrNib    (addrNib),
    .ctl        (ctl),
    .dataOut    (dataOut)
  );

endmodule

// File: tb/sim_serial_rom_ctrl.sv
module sim_serial_rom_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nibbleMode = 1'b1;
  logic       strobe = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [3:0] addrNib = 4'h0;
  logic [3:0] dataOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_rom_ctrl u0 (
    .clk(clk), .rstN(rstN), .nibbleMode(nibbleMode), .strobe(strobe),
    .cmd(cmd), .addrNib(addrNib), .dataOut(dataOut)
  );

  function automatic logic [7:0] refByte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd13;
    return t ^ {a[13:8], a[13:12]} ^ 8'hA5;
  endfunction

  // {cmd[1:0], nib[3:0], chk, hi, addr[13:0]}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {2'b10, 4'h3, 1'b0, 1'b0, 14'h0000},
    {2'b10, 4'h2, 1'b0, 1'b0, 14'h0000},
    {2'b10, 4'h1, 1'b0, 1'b0, 14'h0000},
    {2'b10, 4'h0, 1'b0, 1'b0, 14'h0000},
    {2'b01, 4'h0, 1'b0, 1'b0, 14'h0000},
    {2'b01, 4'h0, 1'b1, 1'b1, 14'h0123},
    {2'b01, 4'h0, 1'b1, 1'b0, 14'h0123},
    {2'b00, 4'h0, 1'b1, 1'b0, 14'h0123},
    {2'b01, 4'h0, 1'b1, 1'b1, 14'h0124},
    {2'b01, 4'h0, 1'b1, 1'b0, 14'h0124}
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: dataOut=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [3:0] n);
    @(negedge clk);
    cmd = c; addrNib = n; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; cmd = 2'b00;
  endtask

  task automatic loadAddr(input logic [15:0] a);
    for (int i = 0; i < 4; i++) issue(2'b10, a[i*4 +: 4]);
  endtask

  function automatic logic [3:0] hiNib(input logic [15:0] a);
    logic [7:0] b;
    b = refByte(a);
    return b[7:4];
  endfunction

  function automatic logic [3:0] loNib(input logic [15:0] a);
    logic [7:0] b;
    b = refByte(a);
    return b[3:0];
  endfunction

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; nibbleMode = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    logic [15:0] ptrW;
    logic [7:0] bb;
    doReset(1'b1);
    check(dataOut, 4'h0, "R7 reset value");

    // table walk: load 0x0123 (R2), dummy (R3), nibble order (R4), nop (R1)
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][21:20], VEC[v][19:16]);
      if (VEC[v][15])
        check(dataOut, VEC[v][14] ? hiNib(16'(VEC[v][13:0])) : loNib(16'(VEC[v][13:0])),
              $sformatf("R4 vector %0d", v));
    end

    // R3: dummy read keeps data
    loadAddr(16'h0050);
    held = dataOut;
    issue(2'b01, 4'h0);
    check(dataOut, held, "R3 dummy read output");
    issue(2'b01, 4'h0);
    check(dataOut, hiNib(16'h0050), "R3 first real read");

    // R1: no strobe means no action
    held = dataOut;
    @(negedge clk);
    cmd = 2'b01;
    repeat (5) @(negedge clk);
    cmd = 2'b00;
    check(dataOut, held, "R1 unstrobed read");
    issue(2'b01, 4'h0);
    check(dataOut, loNib(16'h0050), "R1 pointer unmoved");

    // R6: indirect pointer
    loadAddr(16'h0040);
    issue(2'b11, 4'h0);
    ptrW = {refByte(16'h0041), refByte(16'h0040)} & 16'h3FFF;
    issue(2'b01, 4'h0);
    check(dataOut, hiNib(ptrW), "R6 indirect high nibble");
    issue(2'b01, 4'h0);
    check(dataOut, loNib(ptrW), "R6 indirect low nibble");

    // R2: fifth nibble ignored
    loadAddr(16'h0001);
    issue(2'b10, 4'hF);
    issue(2'b01, 4'h0);
    issue(2'b01, 4'h0);
    check(dataOut, hiNib(16'h0001), "R2 extra nibble ignored");

    // R8: bits above 13 dropped
    loadAddr(16'hC005);
    issue(2'b01, 4'h0);
    issue(2'b01, 4'h0);
    check(dataOut, hiNib(16'h0005), "R8 address mask");

    // R7: read right after reset, no dummy
    doReset(1'b1);
    check(dataOut, 4'h0, "R7 reset clears data");
    issue(2'b01, 4'h0);
    check(dataOut, hiNib(16'h0000), "R7 read after reset");

    // R5: bit mode, LSB first, crossing a byte
    doReset(1'b0);
    loadAddr(16'h0010);
    issue(2'b01, 4'h0);
    bb = refByte(16'h0010);
    for (int i = 0; i < 8; i++) begin
      issue(2'b01, 4'h0);
      check(dataOut, {3'b000, bb[i]}, $sformatf("R5 bit %0d", i));
    end
    bb = refByte(16'h0011);
    issue(2'b01, 4'h0);
    check(dataOut, {3'b000, bb[0]}, "R5 next byte bit 0");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule